// File: doc/BRIEF.md
# Eight-Pin General-Purpose Flag Port

This block provides eight general-purpose flag pins. Software controls them through a small register interface: an address, a write enable, write data and combinational read data. Each pin can be an input or an output. Output pins drive the value that software wrote. Input pins are brought into the core clock domain through a two-flop synchronizer before any read can see them.

A status register records, with sticky bits, which input pins have been seen high. Software clears a status bit by writing zero to it. Writing one to a status bit leaves it alone. For pins set as outputs, the status read shows the value being driven.

A software reboot strobe returns the output data register to zero. The direction register and the status bits keep their values through a reboot.

Top module: `gpio_flag_port`

## Requirements
- R1: Direction register at address 0. Bit i = 1 makes pin i an input and bit i = 0 makes it an output. pinOe[i] is always the inverse of direction bit i.
- R2: After hardware reset, the direction register reads 0xFF (all inputs), the data register holds 0x00, every status bit is 0, pinOut is 0x00 and pinOe is 0x00.
- R3: pinOut carries the data register, written at address 1. A write takes effect at the clock edge that samples it.
- R4: A read of address 1 returns the data register bit for output pins. For input pins it returns the pin value after a two-flop synchronizer, so a pin change shows up in read data after the second rising edge that follows it.
- R5: For an input pin whose synchronized value is high at a rising edge, status bit i is set at that edge. The bit then stays set until it is cleared.
- R6: A write to address 2 clears every status bit whose write data bit is 0. Bits written with 1 are unchanged. If a set condition and a clear fall in the same cycle, the set wins.
- R7: A read of address 2 returns status bit i for input pins and the driven data bit for output pins.
- R8: When softReboot is high at a rising edge, the data register becomes 0x00, and this overrides a data write in the same cycle. Direction and status are unchanged.
- R9: Address 3 is unmapped. It reads as 0x00, and writes to it change no register.
- R10: regRdData is combinational in regAddr and the register state, and it is valid in the same cycle that the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| softReboot | input | 1 | Software reboot strobe; clears the data register |
| regAddr | input | 2 | Register address: 0 direction, 1 data, 2 status, 3 unmapped |
| regWrEn | input | 1 | Write enable, sampled at the rising edge |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr |
| pinIn | input | 8 | Pin input values (asynchronous) |
| pinOut | output | 8 | Pin output values |
| pinOe | output | 8 | Per-pin output enable (1 = drive) |

## Verification
Results arrive at different times after a stimulus:
- Register writes appear one rising edge later.
- A pin change reaches data reads two edges later.
- It reaches the status bits three edges later.
- A read address gives its result in the same cycle.

A behavioural model in the bench delays the pin values with a queue and updates its register state at each rising edge. Outputs are compared a quarter period after every falling edge, so inputs driven at that falling edge have already settled. The directed checks wait the number of edges listed above before they sample.

// File: rtl/gpio_flag_pkg.sv
package gpio_flag_pkg;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_DIR  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   dirWr;
    logic   dataWr;
    logic   statWr;
    logic   dataClr;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/gpio_flag_sync.sv
module gpio_flag_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  localparam int LAST = STAGES - 1;

  initial begin
    if (STAGES < 2) $error("gpio_flag_sync needs at least two stages");
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], asyncIn[b]};
    end
    assign syncOut[b] = chain[LAST];
  end

endmodule

// File: rtl/gpio_flag_ctrl.sv
module gpio_flag_ctrl
  import gpio_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              softReboot,
  output strobe_t           stb
);

  always_comb begin
    stb         = '0;
    stb.dataClr = softReboot;
    unique case (regAddr)
      ADDR_DIR: begin
        stb.rdSel = SEL_DIR;
        stb.dirWr = regWrEn;
      end
      ADDR_DATA: begin
        stb.rdSel  = SEL_DATA;
        stb.dataWr = regWrEn;
      end
      ADDR_STAT: begin
        stb.rdSel  = SEL_STAT;
        stb.statWr = regWrEn;
      end
      default: stb.rdSel = SEL_NONE;
    endcase
  end

  // R9
  no_unmapped_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd3) |-> !(stb.dirWr || stb.dataWr || stb.statWr));

  // R1
  one_write_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.dirWr, stb.dataWr, stb.statWr}));

endmodule

// File: rtl/gpio_flag_datapath.sv
module gpio_flag_datapath
  import gpio_flag_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] syncIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe
);

  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] dataReg;
  logic [WIDTH-1:0] sticky;
  logic [WIDTH-1:0] pinView;
  logic [WIDTH-1:0] statView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          dirReg <= '1;
    else if (stb.dirWr) dirReg <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dataReg <= '0;
    else if (stb.dataClr) dataReg <= '0;
    else if (stb.dataWr)  dataReg <= wrData;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_stat
    logic setCond;
    logic clrCond;
    assign setCond = dirReg[b] & syncIn[b];
    assign clrCond = stb.statWr & ~wrData[b];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        sticky[b] <= 1'b0;
      else if (setCond) sticky[b] <= 1'b1;
      else if (clrCond) sticky[b] <= 1'b0;
    end
    assign pinView[b]  = dirReg[b] ? syncIn[b] : dataReg[b];
    assign statView[b] = dirReg[b] ? sticky[b] : dataReg[b];
  end

  always_comb begin
    unique case (stb.rdSel)
      SEL_DIR:  rdData = dirReg;
      SEL_DATA: rdData = pinView;
      SEL_STAT: rdData = statView;
      default:  rdData = '0;
    endcase
  end

  assign pinOut = dataReg;
  assign pinOe  = ~dirReg;

  // R6
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.statWr |=> ((sticky & ~$past(wrData) & ~$past(dirReg & syncIn)) == '0));

  // R5
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.statWr |=> (($past(sticky) & ~sticky) == '0));

  // R5
  stat_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(dirReg & syncIn)) & ~sticky) == '0));

  // R8
  reboot_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.dataClr |=> (dataReg == '0));

  // R3
  data_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dataWr && !stb.dataClr) |=> (dataReg == $past(wrData)));

endmodule

// File: rtl/gpio_flag_port.sv
module gpio_flag_port
  import gpio_flag_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                softReboot,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [NUM_PINS-1:0] regWrData,
  output logic [NUM_PINS-1:0] regRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe
);

  strobe_t             stb;
  logic [NUM_PINS-1:0] syncIn;

  gpio_flag_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinIn),
    .syncOut (syncIn)
  );

  gpio_flag_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .softReboot (softReboot),
    .stb        (stb)
  );

  gpio_flag_datapath #(.WIDTH(NUM_PINS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (regWrData),
    .syncIn (syncIn),
    .rdData (regRdData),
    .pinOut (pinOut),
    .pinOe  (pinOe)
  );

endmodule

// File: tb/gpio_flag_port_bench.sv
module gpio_flag_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         softReboot = 1'b0;
  logic [1:0]   regAddr = 2'd0;
  logic         regWrEn = 1'b0;
  logic [N-1:0] regWrData = '0;
  logic [N-1:0] regRdData;
  logic [N-1:0] pinIn = '0;
  logic [N-1:0] pinOut;
  logic [N-1:0] pinOe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  gpio_flag_port u_gpio_flag_port (
    .clk(clk), .rstN(rstN), .softReboot(softReboot),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic [N-1:0] mDir = '1;
  logic [N-1:0] mData = '0;
  logic [N-1:0] mSticky = '0;
  logic [N-1:0] pinQ[$];

  function automatic logic [N-1:0] seenPins();
    return (pinQ.size() >= 2) ? pinQ[0] : '0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mDir = '1; mData = '0; mSticky = '0; pinQ.delete();
    end else begin
      logic [N-1:0] seen;
      seen = seenPins();
      for (int b = 0; b < N; b++) begin
        if (mDir[b] && seen[b]) mSticky[b] = 1'b1;
        else if (regWrEn && regAddr == 2'd2 && !regWrData[b]) mSticky[b] = 1'b0;
      end
      if (softReboot) mData = '0;
      else if (regWrEn && regAddr == 2'd1) mData = regWrData;
      if (regWrEn && regAddr == 2'd0) mDir = regWrData;
      pinQ.push_back(pinIn);
      if (pinQ.size() > 2) void'(pinQ.pop_front());
    end
  end

  function automatic logic [N-1:0] expRead(logic [1:0] a);
    logic [N-1:0] r;
    case (a)
      2'd0: r = mDir;
      2'd1: r = (mDir & seenPins()) | (~mDir & mData);
      2'd2: r = (mDir & mSticky) | (~mDir & mData);
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model every cycle, a quarter period after the falling edge
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rstN && !done) begin
      case (regAddr)
        2'd0: check(regRdData, expRead(regAddr), "R1 R10 read dir");
        2'd1: check(regRdData, expRead(regAddr), "R4 R10 read data");
        2'd2: check(regRdData, expRead(regAddr), "R5 R6 R7 read status");
        default: check(regRdData, expRead(regAddr), "R9 read unmapped");
      endcase
      check(pinOut, mData, "R3 pinOut");
      check(pinOe, ~mDir, "R1 pinOe");
    end
  end

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [1:0] a, input logic [N-1:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #(CLK_PERIOD/4);
    check(regRdData, exp, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    // R2 reset state
    rdChk(2'd0, 8'hFF, "R2 dir after reset");
    check(pinOut, 8'h00, "R2 pinOut after reset");
    check(pinOe, 8'h00, "R2 pinOe after reset");
    rdChk(2'd1, 8'h00, "R2 data after reset");
    rdChk(2'd2, 8'h00, "R2 status after reset");

    // R1 R3 low nibble outputs
    wr(2'd0, 8'hF0);
    wr(2'd1, 8'hA5);
    rdChk(2'd0, 8'hF0, "R1 dir written");
    check(pinOe, 8'h0F, "R1 pinOe follows dir");
    check(pinOut, 8'hA5, "R3 pinOut drives data");

    // R4 two-stage synchronizer timing
    @(negedge clk); pinIn = 8'h3C; regAddr = 2'd1;
    #(CLK_PERIOD/4); check(regRdData, 8'h05, "R4 no change before sync");
    @(negedge clk); #(CLK_PERIOD/4); check(regRdData, 8'h05, "R4 one edge still old");
    @(negedge clk); #(CLK_PERIOD/4); check(regRdData, 8'h35, "R4 visible after two edges");

    // R5 R7 status: input bits sticky, output bits show driven value
    rdChk(2'd2, 8'h35, "R5 R7 status set");
    pinIn = 8'h00;
    idle(4);
    rdChk(2'd2, 8'h35, "R5 status stays set");

    // R6 clear with zeros, ones no effect
    wr(2'd2, 8'hEF);
    rdChk(2'd2, 8'h25, "R6 zero clears bit4 only");
    wr(2'd2, 8'hFF);
    rdChk(2'd2, 8'h25, "R6 ones no effect");
    wr(2'd2, 8'h00);
    rdChk(2'd2, 8'h05, "R6 zeros clear all inputs");

    // R6 set wins over clear
    @(negedge clk); pinIn = 8'h80;
    idle(3);
    wr(2'd2, 8'h00);
    rdChk(2'd2, 8'h85, "R6 set wins over clear");

    // R8 soft reboot overrides same-cycle write
    @(negedge clk);
    softReboot = 1'b1; regAddr = 2'd1; regWrData = 8'h0F; regWrEn = 1'b1;
    @(negedge clk);
    softReboot = 1'b0; regWrEn = 1'b0;
    #(CLK_PERIOD/4);
    check(pinOut, 8'h00, "R8 reboot clears data");
    rdChk(2'd0, 8'hF0, "R8 dir kept");
    rdChk(2'd2, 8'h80, "R8 status kept");

    // R9 unmapped address
    wr(2'd3, 8'h00);
    rdChk(2'd3, 8'h00, "R9 unmapped reads zero");
    rdChk(2'd0, 8'hF0, "R9 write ignored dir");
    rdChk(2'd1, 8'h80, "R9 write ignored data");

    // Mixed random traffic against the model
    pinIn = 8'h00;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      regAddr    = 2'($urandom_range(0, 3));
      regWrEn    = ($urandom_range(0, 3) == 0);
      regWrData  = 8'($urandom);
      softReboot = ($urandom_range(0, 15) == 0);
      pinIn      = 8'($urandom);
    end
    @(negedge clk);
    regWrEn = 1'b0; softReboot = 1'b0;
    idle(2);
    finishRun();
  end

endmodule